// File: doc/BRIEF.md
# Dual-Latch Serial DAC Loader

This block receives words over a three-wire serial link (clock, data, and an active-low chip-select that also acts as the load line). It places each received word into one of two 8-bit output latches, and each latch drives an external DAC code. A frame opens when chip-select falls. The first bit clocked in is an address bit that picks the latch, and eight data bits follow it, least significant first. When chip-select rises, the word is committed to the addressed latch. The other latch is left untouched.

All three serial lines are oversampled by a faster system clock through two-flop synchronisers, and their edges are found in that clock domain. A frame with the wrong number of serial clock edges is discarded and reported with a one-cycle error pulse. A successful commit is marked by a one-cycle strobe together with the index of the latch that was written. A shutdown input forces both latches to their preset codes for as long as it is held, so that on release they hold those presets.

Top module: `dual_latch_loader`

## Requirements
- R1: After reset, amp_o equals DEFAULT_AMP (default 8'hC0) and ctr_o equals DEFAULT_CTR (default 8'h40), with load_strobe_o and frame_err_o low.
- R2: A falling edge on cs_n_i opens a new frame and discards any partial shift state from before.
- R3: The first sclk_i rising edge of a frame samples the address bit: 1 selects the amplitude latch (amp_o), 0 selects the centre latch (ctr_o).
- R4: The eight following sclk_i rising edges sample data bits in the order bit 0 first through bit 7 last.
- R5: On a rising edge of cs_n_i after exactly nine sclk_i rising edges, the word is written to the addressed latch, and the other latch keeps its value.
- R6: On a rising edge of cs_n_i after fewer or more than nine sclk_i rising edges, neither latch changes and frame_err_o pulses high for exactly one cycle.
- R7: Every successful write produces a one-cycle load_strobe_o pulse, with load_idx_o = 1 for the amplitude latch and 0 for the centre latch.
- R8: sclk_i edges while cs_n_i is high do not change any output and do not count toward the next frame.
- R9: While shdn_i is high, both latches hold their default codes, completed frames write nothing and give no strobe, and on release the defaults remain.
- R10: A committed word appears on its latch output within six system clock cycles of the cs_n_i rising edge at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| shdn_i | input | 1 | Shutdown; forces both latches to defaults while high |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdata_i | input | 1 | Serial data, sampled on rising sclk_i |
| cs_n_i | input | 1 | Active-low frame select; the rising edge commits |
| amp_o | output | 8 | Amplitude latch contents |
| ctr_o | output | 8 | Centre-voltage latch contents |
| load_strobe_o | output | 1 | One-cycle pulse on each successful write |
| load_idx_o | output | 1 | Latch written with the strobe: 1 amplitude, 0 centre |
| frame_err_o | output | 1 | One-cycle pulse when a frame is rejected |

## Verification
A wrong edge count inside the frame engine appears at the ports within a few cycles of the closing chip-select edge. It shows either as an error pulse where a write was due, or as a write where an error was due. A bit routed to the wrong place in the shift path gives a latch value with bits swapped or shifted, and an address bit read from the wrong place writes the wrong latch. Each of these is visible about three system clocks after the load edge. A shutdown path that fails to hold shows as a latch value other than the preset, or as a strobe pulse while shutdown is asserted.

// File: rtl/dll_pkg.sv
package dll_pkg;
    localparam int WORD_W  = 8;
    localparam int FRAME_N = WORD_W + 1;   // address bit plus data bits
    localparam int CNT_W   = 4;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_N);

    typedef struct packed {
        logic              sel;     // 1: amplitude latch, 0: centre latch
        logic [WORD_W-1:0] word;
    } frame_t;

    function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
        return (c == CNT_MAX) ? c : c + 1'b1;
    endfunction
endpackage

// File: rtl/dll_sync.sv
module dll_sync #(
    parameter int          WIDTH     = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic ff1, ff2;
        always_ff @(posedge clk) begin
            if (rst) begin
                ff1 <= RST_VAL[g];
                ff2 <= RST_VAL[g];
            end else begin
                ff1 <= d_i[g];
                ff2 <= ff1;
            end
        end
        assign q_o[g] = ff2;
    end
endmodule

// File: rtl/dll_frame.sv
module dll_frame
    import dll_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   sdata_s,
    input  logic   cs_n_s,
    output logic   commit_o,
    output frame_t frame_o,
    output logic   err_o
);
    logic              sclk_q, cs_q, busy;
    logic [CNT_W-1:0]  cnt;
    frame_t            acc;

    logic sclk_rise, cs_fall, cs_rise;
    assign sclk_rise = sclk_s & ~sclk_q;
    assign cs_fall   = ~cs_n_s & cs_q;
    assign cs_rise   = cs_n_s & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            busy     <= 1'b0;
            cnt      <= '0;
            acc      <= '0;
            commit_o <= 1'b0;
            err_o    <= 1'b0;
            frame_o  <= '0;
        end else begin
            sclk_q   <= sclk_s;
            cs_q     <= cs_n_s;
            commit_o <= 1'b0;
            err_o    <= 1'b0;
            if (cs_fall) begin
                busy <= 1'b1;
                cnt  <= '0;
                acc  <= '0;
            end else if (cs_rise) begin
                busy <= 1'b0;
                if (busy) begin
                    if (cnt == CNT_FULL) begin
                        commit_o <= 1'b1;
                        frame_o  <= acc;
                    end else begin
                        err_o <= 1'b1;
                    end
                end
            end else if (busy && !cs_n_s && sclk_rise) begin
                cnt <= cnt_step(cnt);
                if (cnt == '0)
                    acc.sel <= sdata_s;
                else if (cnt < CNT_FULL)
                    acc.word <= {sdata_s, acc.word[WORD_W-1:1]};
            end
        end
    end

    // R8: a serial clock edge outside a frame leaves the bit count alone
    a_r8_idle_edges: assert property (@(posedge clk) disable iff (rst)
        (cs_n_s && sclk_rise) |=> $stable(cnt));

    // R6: the error indication lasts a single cycle
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    // R5: a commit and an error never coincide
    a_r5_commit_excl: assert property (@(posedge clk) disable iff (rst)
        !(commit_o && err_o));
endmodule

// File: rtl/dll_latches.sv
module dll_latches
    import dll_pkg::*;
#(
    parameter logic [WORD_W-1:0] DEFAULT_AMP = 8'hC0,
    parameter logic [WORD_W-1:0] DEFAULT_CTR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shdn_i,
    input  logic              commit_i,
    input  frame_t            frame_i,
    output logic [WORD_W-1:0] amp_o,
    output logic [WORD_W-1:0] ctr_o,
    output logic              strobe_o,
    output logic              idx_o
);
    always_ff @(posedge clk) begin
        if (rst || shdn_i) begin
            amp_o    <= DEFAULT_AMP;
            ctr_o    <= DEFAULT_CTR;
            strobe_o <= 1'b0;
            idx_o    <= 1'b0;
        end else begin
            strobe_o <= commit_i;
            if (commit_i) begin
                idx_o <= frame_i.sel;
                if (frame_i.sel) amp_o <= frame_i.word;
                else             ctr_o <= frame_i.word;
            end
        end
    end

    // R9: shutdown forces the presets
    a_r9_shdn_defaults: assert property (@(posedge clk) disable iff (rst)
        shdn_i |=> (amp_o == DEFAULT_AMP && ctr_o == DEFAULT_CTR && !strobe_o));

    // R7: strobe is one cycle wide
    a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

    // R5: the latch not addressed keeps its value
    a_r5_other_amp: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && !idx_o) |-> $stable(amp_o));
    a_r5_other_ctr: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && idx_o) |-> $stable(ctr_o));
endmodule

// File: rtl/dual_latch_loader.sv
module dual_latch_loader
    import dll_pkg::*;
#(
    parameter logic [7:0] DEFAULT_AMP = 8'hC0,
    parameter logic [7:0] DEFAULT_CTR = 8'h40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       shdn_i,
    input  logic       sclk_i,
    input  logic       sdata_i,
    input  logic       cs_n_i,
    output logic [7:0] amp_o,
    output logic [7:0] ctr_o,
    output logic       load_strobe_o,
    output logic       load_idx_o,
    output logic       frame_err_o
);
    logic [2:0] raw, syn;
    logic       commit;
    frame_t     frame;

    assign raw = {cs_n_i, sdata_i, sclk_i};

    dll_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (syn)
    );

    dll_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (syn[0]),
        .sdata_s  (syn[1]),
        .cs_n_s   (syn[2]),
        .commit_o (commit),
        .frame_o  (frame),
        .err_o    (frame_err_o)
    );

    dll_latches #(.DEFAULT_AMP(DEFAULT_AMP), .DEFAULT_CTR(DEFAULT_CTR)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .shdn_i   (shdn_i),
        .commit_i (commit),
        .frame_i  (frame),
        .amp_o    (amp_o),
        .ctr_o    (ctr_o),
        .strobe_o (load_strobe_o),
        .idx_o    (load_idx_o)
    );

    // R6: a rejected frame leaves both latches untouched
    a_r6_no_update: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> ($stable(amp_o) && $stable(ctr_o)));
endmodule

// File: tb/dual_latch_loader_tb.sv
module dual_latch_loader_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shdn = 1'b0, sclk = 1'b0, sdata = 1'b0, cs_n = 1'b1;
    logic [7:0] amp, ctr;
    logic strobe, idx, ferr;

    int n_tests = 0, n_fail = 0;
    int strobes = 0, errs = 0;
    logic last_idx = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_latch_loader u_dut (
        .clk(clk), .rst(rst), .shdn_i(shdn), .sclk_i(sclk), .sdata_i(sdata),
        .cs_n_i(cs_n), .amp_o(amp), .ctr_o(ctr), .load_strobe_o(strobe),
        .load_idx_o(idx), .frame_err_o(ferr)
    );

    always @(posedge clk) begin
        if (strobe) begin
            strobes  <= strobes + 1;
            last_idx <= idx;
        end
        if (ferr) errs <= errs + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // edges: number of sclk rising edges inside the frame
    task automatic send_frame(input logic sel, input logic [7:0] data, input int edges);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < edges; i++) begin
            sdata = (i == 0) ? sel : ((i <= 8) ? data[i-1] : 1'b0);
            wait_clk(2);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(2);
        end
        cs_n = 1'b1;
    endtask

    // {edges[3:0], sel, data[7:0]}
    localparam logic [12:0] VEC [9] = '{
        {4'd9,  1'b1, 8'h3C},
        {4'd9,  1'b0, 8'hA5},
        {4'd9,  1'b1, 8'h01},
        {4'd9,  1'b0, 8'h80},
        {4'd5,  1'b1, 8'hFF},
        {4'd11, 1'b0, 8'h11},
        {4'd1,  1'b1, 8'h77},
        {4'd0,  1'b0, 8'h00},
        {4'd9,  1'b1, 8'hFE}
    };

    initial begin
        int exp_amp, exp_ctr, s0, e0;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        chk("R1 amp reset", amp, 8'hC0);
        chk("R1 ctr reset", ctr, 8'h40);
        chk("R1 strobe idle", strobe, 0);
        chk("R1 err idle", ferr, 0);
        exp_amp = 8'hC0;
        exp_ctr = 8'h40;

        // table walk: R3 R4 R5 R6 R7
        for (int k = 0; k < 9; k++) begin
            logic [3:0] ed;
            logic       sl;
            logic [7:0] dt;
            {ed, sl, dt} = VEC[k];
            s0 = strobes;
            e0 = errs;
            send_frame(sl, dt, int'(ed));
            wait_clk(6);   // R10 window
            if (ed == 4'd9) begin
                if (sl) exp_amp = dt; else exp_ctr = dt;
                chk("R5/R10 strobe count", strobes - s0, 1);
                chk("R7 load index", last_idx, sl);
                chk("R6 no error on good frame", errs - e0, 0);
            end else begin
                chk("R6 error pulse count", errs - e0, 1);
                chk("R6 no strobe on bad frame", strobes - s0, 0);
            end
            chk("R3/R4 amp value", amp, exp_amp);
            chk("R3/R4 ctr value", ctr, exp_ctr);
        end

        // R8: serial clock toggling with chip-select high
        s0 = strobes;
        e0 = errs;
        for (int i = 0; i < 5; i++) begin
            sdata = 1'b1;
            sclk = 1'b1; wait_clk(4);
            sclk = 1'b0; wait_clk(4);
        end
        chk("R8 no strobe idle", strobes - s0, 0);
        chk("R8 no error idle", errs - e0, 0);
        chk("R8 amp held", amp, exp_amp);
        // the idle edges must not count toward this frame
        send_frame(1'b0, 8'h5A, 9);
        wait_clk(6);
        exp_ctr = 8'h5A;
        chk("R8 next frame clean", ctr, exp_ctr);
        chk("R8 next frame strobe", strobes - s0, 1);

        // R2: a frame aborted by an early rise, then a fresh good one
        send_frame(1'b1, 8'h99, 4);
        wait_clk(6);
        send_frame(1'b1, 8'h24, 9);
        wait_clk(6);
        exp_amp = 8'h24;
        chk("R2 fresh frame amp", amp, exp_amp);

        // R9: shutdown
        shdn = 1'b1;
        wait_clk(2);
        chk("R9 amp default in shutdown", amp, 8'hC0);
        chk("R9 ctr default in shutdown", ctr, 8'h40);
        s0 = strobes;
        send_frame(1'b0, 8'h33, 9);
        wait_clk(6);
        chk("R9 no strobe in shutdown", strobes - s0, 0);
        chk("R9 ctr still default", ctr, 8'h40);
        shdn = 1'b0;
        wait_clk(3);
        chk("R9 amp default after release", amp, 8'hC0);
        chk("R9 ctr default after release", ctr, 8'h40);
        send_frame(1'b1, 8'h6B, 9);
        wait_clk(6);
        chk("R5 write after release", amp, 8'h6B);
        chk("R5 other latch kept", ctr, 8'h40);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule